// File: doc/BRIEF.md
# USB OUT Endpoint Single-Bank Receive Buffer

This block is the receive store and handshake decision for one USB device OUT endpoint that has a single buffer bank. On the bus side it takes a stream that has already been decoded: a packet-start strobe, byte strobes with data, and a packet-end strobe together with a CRC-good indication. For every packet it answers with a one-cycle handshake request, either ACK or NAK. Isochronous traffic is not supported.

After a good packet is stored, the processor owns the bank. While the processor owns it, any further OUT packet is refused with a NAK, and the buffer stays as it is. Firmware reads the status word to learn the byte count. It pops the payload through one data port and then writes the clear strobe. That write hands the bank back to the bus, so the next packet overwrites whatever firmware did not read. The interrupt line shows the ownership flag.

Top module: `usb_out_ep_buf`

## Requirements
- R1: While rst_ni is low and just after it rises, the full flag, byte count, both pointers and irq_o are zero, and hs_valid_o is low.
- R2: A packet that starts while the bank is free and ends with crc_ok_i high makes hs_valid_o high for exactly one cycle, in the cycle after the end strobe, with hs_ack_o=1 (ACK). The full flag is set at that same edge.
- R3: A packet that starts while the full flag is set and ends with crc_ok_i high produces a handshake with hs_ack_o=0 (NAK). Buffer contents and byte count do not change.
- R4: irq_o is high in exactly those cycles where the full flag (stat_o[0]) is high.
- R5: stat_o[CNT_W:1] holds the number of bytes stored for the last accepted packet. stat_o[0] is the full flag.
- R6: rd_data_o shows the next unread byte. Each cycle with rd_i high advances to the following byte, so bytes come out in arrival order.
- R7: Once every stored byte has been read, rd_data_o is zero and further rd_i pulses do not advance the read position.
- R8: A clr_i pulse drops the full flag. The next good packet is then accepted with an ACK and overwrites the buffer.
- R9: Bytes beyond DEPTH in one packet are dropped, and the count saturates at DEPTH.
- R10: A packet that ends with crc_ok_i low gets no handshake, does not set the flag, and leaves the count unchanged.
- R11: Storing a new packet resets the read position to its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_start_i | input | 1 | OUT data packet begins |
| byte_valid_i | input | 1 | byte_i carries a payload byte |
| byte_i | input | DATA_W | Payload byte |
| pkt_end_i | input | 1 | Packet ends |
| crc_ok_i | input | 1 | CRC good, qualified by pkt_end_i |
| hs_valid_o | output | 1 | Handshake request pulse |
| hs_ack_o | output | 1 | 1 = ACK, 0 = NAK, valid with hs_valid_o |
| stat_o | output | CNT_W+1 | {byte count, full flag} |
| rd_i | input | 1 | Pop one byte from the data port |
| rd_data_o | output | DATA_W | Data port, next unread byte |
| clr_i | input | 1 | Release the bank (clear the full flag) |
| irq_o | output | 1 | Interrupt, high while the bank is full |

## Verification
The bench builds the block with its default values: DEPTH=64 and DATA_W=8, which gives a 7-bit count. With 64 entries, a 70-byte packet is enough to saturate the count and drop the tail, and the bench can still read back every stored byte and one more read past the end. Short packets, empty packets, a NAKed packet, a CRC-bad packet and a release between packets cover ownership, overwrite and the read-pointer reset.

// File: rtl/usb_out_ep_pkg.sv
`timescale 1ns/1ps
package usb_out_ep_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_STORE = 2'd1,
    RX_DROP  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/usb_out_ep_bank.sv
`timescale 1ns/1ps
module usb_out_ep_bank #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int AW     = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/usb_out_ep_rx_ctrl.sv
`timescale 1ns/1ps
module usb_out_ep_rx_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7,
  parameter int AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_start_i,
  input  logic             byte_valid_i,
  input  logic             pkt_end_i,
  input  logic             crc_ok_i,
  input  logic             clr_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic             load_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hs_valid_o,
  output logic             hs_ack_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] wr_ptr_q, wr_ptr_d, wr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             full_q, hs_valid_q, hs_ack_q;
  logic             room, store_end, drop_end;

  assign room      = wr_ptr_q < DEPTH_C;
  assign we_o      = (state_q == RX_STORE) && !pkt_start_i && byte_valid_i && room;
  assign waddr_o   = wr_ptr_q[AW-1:0];
  assign wr_nxt    = we_o ? wr_ptr_q + CNT_W'(1) : wr_ptr_q;
  assign store_end = (state_q == RX_STORE) && !pkt_start_i && pkt_end_i;
  assign drop_end  = (state_q == RX_DROP) && !pkt_start_i && pkt_end_i;
  // a stored packet with good CRC hands the bank to the processor
  assign load_o    = store_end && crc_ok_i;

  always_comb begin
    state_d  = state_q;
    wr_ptr_d = wr_nxt;
    if (pkt_start_i) begin
      state_d  = full_q ? RX_DROP : RX_STORE;
      wr_ptr_d = '0;
    end else if (store_end || drop_end) begin
      state_d = RX_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      wr_ptr_q   <= '0;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_ack_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      wr_ptr_q   <= wr_ptr_d;
      hs_valid_q <= load_o || (drop_end && crc_ok_i);
      hs_ack_q   <= load_o;
      if (load_o) cnt_q <= wr_nxt;
      if (load_o)     full_q <= 1'b1;
      else if (clr_i) full_q <= 1'b0;
    end
  end

  assign full_o     = full_q;
  assign cnt_o      = cnt_q;
  assign hs_valid_o = hs_valid_q;
  assign hs_ack_o   = hs_ack_q;

  assert_hs_after_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> $past(pkt_end_i));
  assert_ack_sets_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> (hs_valid_o && hs_ack_o));
  assert_nak_keeps_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && !hs_ack_o) |-> $stable(cnt_q));
  assert_cnt_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
  assert_bad_crc_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && !crc_ok_i) |=> !hs_valid_o);
  assert_no_write_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !$past(full_q)) |-> !we_o || $past(pkt_start_i) == 1'b0);
endmodule

// File: rtl/usb_out_ep_rd_port.sv
`timescale 1ns/1ps
module usb_out_ep_rd_port #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter int AW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [CNT_W-1:0] rd_ptr_q;
  logic             avail;

  assign avail     = rd_ptr_q < cnt_i;
  assign raddr_o   = rd_ptr_q[AW-1:0];
  assign rd_data_o = avail ? mem_rdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rd_ptr_q <= '0;
    else if (load_i)         rd_ptr_q <= '0;
    else if (rd_i && avail)  rd_ptr_q <= rd_ptr_q + CNT_W'(1);
  end

  assert_rd_ptr_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr_q <= cnt_i);
  assert_exhausted_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ptr_q == cnt_i) |-> (rd_data_o == '0));
  assert_ptr_rewind_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rd_ptr_q == '0));
endmodule

// File: rtl/usb_out_ep_buf.sv
`timescale 1ns/1ps
module usb_out_ep_buf #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_start_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              pkt_end_i,
  input  logic              crc_ok_i,
  output logic              hs_valid_o,
  output logic              hs_ack_o,
  output logic [CNT_W:0]    stat_o,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              clr_i,
  output logic              irq_o
);
  logic              we, load, full;
  logic [AW-1:0]     waddr, raddr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] mem_rdata;

  usb_out_ep_rx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .pkt_start_i, .byte_valid_i, .pkt_end_i, .crc_ok_i, .clr_i,
    .we_o(we), .waddr_o(waddr), .load_o(load), .full_o(full), .cnt_o(cnt),
    .hs_valid_o, .hs_ack_o
  );

  usb_out_ep_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_bank (
    .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(byte_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  usb_out_ep_rd_port #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AW(AW)) u_rd (
    .clk_i, .rst_ni, .rd_i, .load_i(load), .cnt_i(cnt),
    .mem_rdata_i(mem_rdata), .raddr_o(raddr), .rd_data_o
  );

  assign stat_o = {cnt, full};
  assign irq_o  = full;

  assert_irq_tracks_own_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !load && stat_o[0]) |=> !irq_o);
endmodule

// File: tb/usb_out_ep_buf_tb.sv
`timescale 1ns/1ps
module usb_out_ep_buf_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       pkt_start_i = 0, byte_valid_i = 0, pkt_end_i = 0, crc_ok_i = 0;
  logic [7:0] byte_i = '0;
  logic       rd_i = 0, clr_i = 0;
  logic       hs_valid_o, hs_ack_o, irq_o;
  logic [7:0] stat_o, rd_data_o;

  usb_out_ep_buf u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int   n_chk = 0, n_bad = 0;
  bit   hs_q[$];
  logic [7:0] exp_mem [64];
  int   exp_cnt = 0, exp_rd = 0;
  bit   exp_full = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // monitor: every handshake must match the next queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && hs_valid_o) begin
      n_chk++;
      if (hs_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected handshake act=%0d exp=none", hs_ack_o);
      end else begin
        bit e;
        e = hs_q.pop_front();
        if (hs_ack_o != e) begin
          n_bad++;
          $display("FAIL %s handshake act=%0d exp=%0d", e ? "R2" : "R3", hs_ack_o, e);
        end
      end
    end
  end

  task automatic send_pkt(int n, bit good, int seed);
    bit was_full = exp_full;
    if (good) hs_q.push_back(!was_full);
    pkt_start_i = 1; tick(); pkt_start_i = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid_i = 1; byte_i = 8'((seed + i * 7) & 8'hff);
      if (!was_full && i < 64) exp_mem[i] = byte_i;
      tick();
    end
    byte_valid_i = 0;
    pkt_end_i = 1; crc_ok_i = good; tick();
    pkt_end_i = 0; crc_ok_i = 0;
    if (good && !was_full) begin
      exp_full = 1; exp_cnt = (n > 64) ? 64 : n; exp_rd = 0;
    end
    repeat (3) tick();
  endtask

  task automatic chk_stat(string tag);
    @(negedge clk_i);
    chk({tag, " full"}, stat_o[0], exp_full);
    chk({tag, " count"}, stat_o[7:1], exp_cnt);
    chk({tag, " R4 irq"}, irq_o, exp_full);
  endtask

  task automatic rd_chk(string tag);
    int e;
    @(negedge clk_i);
    e = (exp_rd < exp_cnt) ? exp_mem[exp_rd] : 0;
    chk(tag, rd_data_o, e);
    rd_i = 1; tick(); rd_i = 0;
    if (exp_rd < exp_cnt) exp_rd++;
  endtask

  task automatic release_bank();
    clr_i = 1; tick(); clr_i = 0; exp_full = 0;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) tick();
    @(negedge clk_i);
    chk("R1 reset stat", stat_o, 0);
    chk("R1 reset irq", irq_o, 0);
    chk("R1 reset hs", hs_valid_o, 0);
    rst_ni = 1; tick();
    chk_stat("R1");
    chk("R7 empty read", rd_data_o, 0);

    send_pkt(5, 1, 16);          // R2 ACK, R5 count
    chk_stat("R2 R5");
    send_pkt(9, 1, 200);         // R3 NAK while owned
    chk_stat("R3");
    for (int i = 0; i < 5; i++) rd_chk("R3 R6 data order");
    rd_chk("R7 past end");
    rd_chk("R7 still zero");
    chk_stat("R7");

    release_bank();
    chk_stat("R8 released");
    send_pkt(3, 1, 90);          // R8 overwrite, R11 pointer rewound
    chk_stat("R8");
    rd_chk("R11 first byte after reload");
    rd_chk("R8 overwrite");

    release_bank();
    send_pkt(4, 0, 55);          // R10 bad CRC
    chk_stat("R10");
    send_pkt(2, 1, 33);
    chk_stat("R10 recover");
    rd_chk("R11 rewind");
    rd_chk("R6 second");
    rd_chk("R7 end");

    release_bank();
    send_pkt(70, 1, 3);          // R9 saturation
    chk_stat("R9");
    for (int i = 0; i < 64; i++) rd_chk("R9 R6 long data");
    rd_chk("R9 R7 dropped tail");

    release_bank();
    send_pkt(0, 1, 0);           // empty packet
    chk_stat("R2 R5 empty");
    rd_chk("R7 empty packet");

    repeat (3) tick();
    chk("R2 R3 handshakes consumed", hs_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule